// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the bus-facing register bank of a serial port. It is a pipelined bus slave with four 32-bit word registers: status, control, received byte and byte to send. Receiver and transmitter cores sit beside it and do the bit timing. The bank stores the line configuration and passes it to both cores as decoded fields. It collects receive events from the receiver, together with their byte and error flags. It gives the transmitter a one-cycle start pulse and the byte to send.

Reading has side effects. A status read returns the sticky error flags and then clears them. A read of the received byte returns it and then empties the receive holder. When a control write changes the stored configuration, the bank sends a cancel pulse to both cores and ends any send in progress.

The bank uses three two-state machines:
- The bus machine moves from `BUS_IDLE` to `BUS_RESP` whenever an access is accepted. It returns to `BUS_IDLE` on the first cycle with no access.
- The receive holder moves from `RX_EMPTY` to `RX_FULL` when a byte is stored. It returns to `RX_EMPTY` when the received-byte register is read and no new byte arrives in that cycle.
- The send tracker moves from `TX_IDLE` to `TX_BUSY` when the byte-to-send register is written. It returns to `TX_IDLE` on the transmitter's done pulse or on a configuration change.

Top module: `serial_regbank`

## Requirements
- R1: The bank raises `bus_ack_o` for one cycle, in the cycle after each cycle in which `bus_stb_i` and `bus_cyc_i` are both high, and at no other time. Back-to-back accesses receive back-to-back acknowledges. `bus_stall_o` is always low.
- R2: `rst_i` is synchronous and active high. After reset, status reads 0x00000002 (only the transmit-empty flag set), control and the received byte read 0, and `tx_start_o` and `link_cancel_o` are low.
- R3: The status word at address 0x0 has these bits: bit 0 = receive holder full, bit 1 = transmit empty (no send in progress), bit 2 = overrun, bit 3 = framing error, bit 4 = parity error. Bits 31..5 read 0.
- R4: A write to address 0x4 updates the control word byte lane by lane: lane k is written only when `bus_sel_i[k]` is high. Bits 15..4 always read 0. The outputs show the stored fields: parity at bits 1..0 (00 none, 01 odd, 10 even), two stop bits at bit 2, eight data bits at bit 3, and the baud increment at bits 31..16.
- R5: A control write that changes the stored value gives a one-cycle `link_cancel_o` pulse in the same cycle as its acknowledge. A control write that leaves the value unchanged gives no pulse.
- R6: A receive event (`rx_valid_i`) with the holder empty stores `rx_byte_i` at bits 7..0 of address 0x8 and sets the full flag. A read of 0x8 returns the byte and then clears the register to 0 and the full flag.
- R7: A receive event while the holder is full, and no read of 0x8 happens in that cycle, sets the overrun flag and keeps the old byte. If a read of 0x8 happens in the same cycle, the new byte is stored and no overrun is flagged.
- R8: `rx_parity_err_i` and `rx_frame_err_i`, qualified by `rx_valid_i`, set the parity and framing flags. A status read returns the parity, framing and overrun flags and then clears them. A flag set by an event in the same cycle as the read stays set.
- R9: A write to address 0xC while transmit empty is high gives a one-cycle `tx_start_o` pulse with the acknowledge. It puts bits 7..0 on `tx_byte_o` and clears transmit empty until `tx_done_i`. A write to 0xC while a send is in progress is dropped.
- R10: A configuration change ends a send in progress, so transmit empty reads 1 again.
- R11: Only exact word addresses 0x0, 0x4, 0x8 and 0xC are mapped. Writes to 0x0, to 0x8 and to unmapped addresses change nothing. Reads of 0xC and of unmapped addresses return 0 and are still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_adr_i | input | 32 | Byte address of the access |
| bus_dat_i | input | 32 | Write data |
| bus_dat_o | output | 32 | Read data, valid with the acknowledge |
| bus_sel_i | input | 4 | Byte lane selects |
| bus_we_i | input | 1 | High for a write access |
| bus_stb_i | input | 1 | Access strobe |
| bus_cyc_i | input | 1 | Bus cycle in progress |
| bus_ack_o | output | 1 | Access acknowledge |
| bus_stall_o | output | 1 | Stall, tied low |
| rx_valid_i | input | 1 | Receiver has finished a frame |
| rx_byte_i | input | 8 | Received byte |
| rx_parity_err_i | input | 1 | Frame had a parity mismatch |
| rx_frame_err_i | input | 1 | Frame had a low stop bit |
| tx_done_i | input | 1 | Transmitter finished the byte |
| tx_start_o | output | 1 | One-cycle send request |
| tx_byte_o | output | 8 | Byte to send |
| link_cancel_o | output | 1 | One-cycle abort for both serial cores |
| cfg_parity_o | output | 2 | Parity mode |
| cfg_two_stop_o | output | 1 | Two stop bits selected |
| cfg_eight_bit_o | output | 1 | Eight data bits selected |
| cfg_incr_o | output | 16 | Baud accumulator increment |

## Verification
The register map is exercised in several ways: full-word and single-lane control writes, writes that leave the value unchanged, and single-byte receptions. These show byte masking and change detection. The bench also drives a second byte before the first is read, receive events in the same cycle as a status read or a received-byte read, and a send request while a send is in progress. These separate the set-over-clear priority from plain clear-on-read. Writes to read-only and unmapped addresses, misaligned addresses and a run of three back-to-back reads show that decoding and pipelined acknowledges do not disturb stored state.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

    localparam int unsigned REG_IDX_W = 2;
    localparam int unsigned CFG_LOW_W = 4;

    localparam int unsigned ST_RXNE = 0;
    localparam int unsigned ST_TXE  = 1;
    localparam int unsigned ST_OVR  = 2;
    localparam int unsigned ST_FRM  = 3;
    localparam int unsigned ST_PE   = 4;

    localparam int unsigned CF_PAR_LSB = 0;
    localparam int unsigned CF_PAR_W   = 2;
    localparam int unsigned CF_STOP    = 2;
    localparam int unsigned CF_SIZE    = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_STATUS  = 2'd0,
        IDX_CONTROL = 2'd1,
        IDX_RXDATA  = 2'd2,
        IDX_TXDATA  = 2'd3
    } reg_idx_e;

    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;
    typedef enum logic {RX_EMPTY, RX_FULL}  rx_state_e;
    typedef enum logic {TX_IDLE,  TX_BUSY}  tx_state_e;

    typedef struct packed {
        logic rd_status;
        logic rd_rxdata;
        logic wr_control;
        logic wr_txdata;
    } access_t;

endpackage

// File: rtl/regbank_bus.sv
module regbank_bus
    import serial_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic              stb_i,
    input  logic              cyc_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] control_i,
    input  logic [DATA_W-1:0] rxdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output access_t           access_o
);
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_MSB = IDX_LSB + REG_IDX_W;

    bus_state_e        state_q, state_d;
    logic              accept;
    logic              hit;
    reg_idx_e          idx;
    logic [DATA_W-1:0] read_mux;
    logic [DATA_W-1:0] rdata_q;

    // Any strobe inside a cycle is taken; only exact word addresses decode.
    assign accept = stb_i && cyc_i;
    assign hit    = accept
                 && (adr_i[ADDR_W-1:IDX_MSB] == '0)
                 && (adr_i[IDX_LSB-1:0] == '0);
    assign idx    = reg_idx_e'(adr_i[IDX_LSB +: REG_IDX_W]);

    always_comb begin
        access_o = '0;
        if (hit) begin
            unique case (idx)
                IDX_STATUS:  access_o.rd_status  = !we_i;
                IDX_CONTROL: access_o.wr_control = we_i;
                IDX_RXDATA:  access_o.rd_rxdata  = !we_i;
                IDX_TXDATA:  access_o.wr_txdata  = we_i;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_STATUS:  read_mux = status_i;
            IDX_CONTROL: read_mux = control_i;
            IDX_RXDATA:  read_mux = rxdata_i;
            IDX_TXDATA:  read_mux = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = accept ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = accept ? BUS_RESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data is captured before any clear-on-read takes effect.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
        end else if (hit && !we_i) begin
            rdata_q <= read_mux;
        end else begin
            rdata_q <= '0;
        end
    end

    always_comb begin
        ack_o   = (state_q == BUS_RESP);
        rdata_o = rdata_q;
    end

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
    import serial_regbank_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SEL_W    = DATA_W / 8,
    parameter int unsigned INCR_LSB = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] control_o,
    output logic              change_o,
    output logic              cancel_o
);
    localparam int unsigned   LANE_W   = DATA_W / SEL_W;
    localparam logic [DATA_W-1:0] HI_MASK  = {DATA_W{1'b1}} << INCR_LSB;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-CFG_LOW_W){1'b0}}, {CFG_LOW_W{1'b1}}};
    localparam logic [DATA_W-1:0] WR_MASK  = HI_MASK | LOW_MASK;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] next_val;
    logic              cancel_q;

    for (genvar lane = 0; lane < SEL_W; lane++) begin : g_lane
        assign merged[lane*LANE_W +: LANE_W] = sel_i[lane]
            ? wdata_i[lane*LANE_W +: LANE_W]
            : ctrl_q[lane*LANE_W +: LANE_W];
    end

    assign next_val = merged & WR_MASK;
    assign change_o = wr_i && (next_val != ctrl_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q   <= '0;
            cancel_q <= 1'b0;
        end else begin
            cancel_q <= change_o;
            if (wr_i) begin
                ctrl_q <= next_val;
            end
        end
    end

    assign control_o = ctrl_q;
    assign cancel_o  = cancel_q;

endmodule

// File: rtl/regbank_rx.sv
module regbank_rx
    import serial_regbank_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rd_status_i,
    input  logic              rd_rxdata_i,
    output logic              rxne_o,
    output logic              ovr_o,
    output logic              frm_o,
    output logic              par_o,
    output logic [BYTE_W-1:0] byte_o
);
    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] byte_q;
    logic              ovr_q, frm_q, par_q;
    logic              overrun;
    logic              take_byte;

    // A same-cycle read of the holder frees room for the new byte.
    assign overrun   = valid_i && (state_q == RX_FULL) && !rd_rxdata_i;
    assign take_byte = valid_i && !overrun;

    always_comb begin
        unique case (state_q)
            RX_EMPTY: state_d = take_byte ? RX_FULL : RX_EMPTY;
            RX_FULL:  state_d = (rd_rxdata_i && !take_byte) ? RX_EMPTY : RX_FULL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            byte_q <= '0;
            ovr_q  <= 1'b0;
            frm_q  <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (take_byte) begin
                byte_q <= byte_i;
            end else if (rd_rxdata_i) begin
                byte_q <= '0;
            end
            // Setting from an event outranks clearing by a status read.
            if (overrun) begin
                ovr_q <= 1'b1;
            end else if (rd_status_i) begin
                ovr_q <= 1'b0;
            end
            if (valid_i && ferr_i) begin
                frm_q <= 1'b1;
            end else if (rd_status_i) begin
                frm_q <= 1'b0;
            end
            if (valid_i && perr_i) begin
                par_q <= 1'b1;
            end else if (rd_status_i) begin
                par_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rxne_o = (state_q == RX_FULL);
        ovr_o  = ovr_q;
        frm_o  = frm_q;
        par_o  = par_q;
        byte_o = byte_q;
    end

endmodule

// File: rtl/regbank_tx.sv
module regbank_tx
    import serial_regbank_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wbyte_i,
    input  logic              done_i,
    input  logic              abort_i,
    output logic              busy_o,
    output logic              start_o,
    output logic [BYTE_W-1:0] byte_o
);
    tx_state_e         state_q, state_d;
    logic              launch;
    logic              start_q;
    logic [BYTE_W-1:0] byte_q;

    assign launch = (state_q == TX_IDLE) && wr_i && !abort_i;

    always_comb begin
        unique case (state_q)
            TX_IDLE: state_d = launch ? TX_BUSY : TX_IDLE;
            TX_BUSY: state_d = (abort_i || done_i) ? TX_IDLE : TX_BUSY;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= 1'b0;
            byte_q  <= '0;
        end else begin
            start_q <= launch;
            if (launch) begin
                byte_q <= wbyte_i;
            end
        end
    end

    always_comb begin
        busy_o  = (state_q == TX_BUSY);
        start_o = start_q;
        byte_o  = byte_q;
    end

endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
    import serial_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned INCR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] bus_adr_i,
    input  logic [DATA_W-1:0] bus_dat_i,
    output logic [DATA_W-1:0] bus_dat_o,
    input  logic [DATA_W/8-1:0] bus_sel_i,
    input  logic              bus_we_i,
    input  logic              bus_stb_i,
    input  logic              bus_cyc_i,
    output logic              bus_ack_o,
    output logic              bus_stall_o,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic              rx_parity_err_i,
    input  logic              rx_frame_err_i,
    input  logic              tx_done_i,
    output logic              tx_start_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              link_cancel_o,
    output logic [1:0]        cfg_parity_o,
    output logic              cfg_two_stop_o,
    output logic              cfg_eight_bit_o,
    output logic [INCR_W-1:0] cfg_incr_o
);
    localparam int unsigned SEL_W    = DATA_W / 8;
    localparam int unsigned INCR_LSB = DATA_W - INCR_W;

    access_t           access;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] control_word;
    logic [DATA_W-1:0] rxdata_word;
    logic              cfg_change;
    logic              rxne, ovr, frm, par, tx_busy;
    logic [BYTE_W-1:0] rx_held;

    regbank_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_u (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .adr_i     (bus_adr_i),
        .stb_i     (bus_stb_i),
        .cyc_i     (bus_cyc_i),
        .we_i      (bus_we_i),
        .status_i  (status_word),
        .control_i (control_word),
        .rxdata_i  (rxdata_word),
        .ack_o     (bus_ack_o),
        .rdata_o   (bus_dat_o),
        .access_o  (access)
    );

    regbank_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .INCR_LSB(INCR_LSB)) ctrl_u (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (access.wr_control),
        .wdata_i   (bus_dat_i),
        .sel_i     (bus_sel_i),
        .control_o (control_word),
        .change_o  (cfg_change),
        .cancel_o  (link_cancel_o)
    );

    regbank_rx #(.BYTE_W(BYTE_W)) rx_u (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .valid_i     (rx_valid_i),
        .byte_i      (rx_byte_i),
        .perr_i      (rx_parity_err_i),
        .ferr_i      (rx_frame_err_i),
        .rd_status_i (access.rd_status),
        .rd_rxdata_i (access.rd_rxdata),
        .rxne_o      (rxne),
        .ovr_o       (ovr),
        .frm_o       (frm),
        .par_o       (par),
        .byte_o      (rx_held)
    );

    regbank_tx #(.BYTE_W(BYTE_W)) tx_u (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (access.wr_txdata),
        .wbyte_i (bus_dat_i[BYTE_W-1:0]),
        .done_i  (tx_done_i),
        .abort_i (cfg_change),
        .busy_o  (tx_busy),
        .start_o (tx_start_o),
        .byte_o  (tx_byte_o)
    );

    always_comb begin
        status_word          = '0;
        status_word[ST_RXNE] = rxne;
        status_word[ST_TXE]  = !tx_busy;
        status_word[ST_OVR]  = ovr;
        status_word[ST_FRM]  = frm;
        status_word[ST_PE]   = par;
    end

    assign rxdata_word     = {{(DATA_W-BYTE_W){1'b0}}, rx_held};
    assign bus_stall_o     = 1'b0;
    assign cfg_parity_o    = control_word[CF_PAR_LSB +: CF_PAR_W];
    assign cfg_two_stop_o  = control_word[CF_STOP];
    assign cfg_eight_bit_o = control_word[CF_SIZE];
    assign cfg_incr_o      = control_word[INCR_LSB +: INCR_W];

endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned INCR_W = 16,
    parameter int unsigned HI_W   = 27
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] adr_i,
    input logic              stb_i,
    input logic              cyc_i,
    input logic              we_i,
    input logic              ack_i,
    input logic [HI_W-1:0]   rdata_hi_i,
    input logic              start_i,
    input logic              cancel_i,
    input logic [1:0]        parity_i,
    input logic [INCR_W-1:0] incr_i
);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CONTROL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_TXDATA  = ADDR_W'(12);

    logic taken;
    assign taken = stb_i && cyc_i;

    assert_ack_follows_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        taken |=> ack_i);

    assert_no_spurious_ack_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        !taken |=> !ack_i);

    assert_status_reserved_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && $past(taken && !we_i && adr_i == A_STATUS)) |-> (rdata_hi_i == '0));

    assert_cancel_cause_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        cancel_i |-> $past(taken && we_i && adr_i == A_CONTROL));

    assert_start_cause_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |-> $past(taken && we_i && adr_i == A_TXDATA));

    assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(taken && we_i && adr_i == A_CONTROL) |-> ($stable(incr_i) && $stable(parity_i)));

endmodule

bind serial_regbank serial_regbank_chk #(
    .ADDR_W (ADDR_W),
    .INCR_W (INCR_W),
    .HI_W   (DATA_W - serial_regbank_pkg::ST_PE - 1)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adr_i      (bus_adr_i),
    .stb_i      (bus_stb_i),
    .cyc_i      (bus_cyc_i),
    .we_i       (bus_we_i),
    .ack_i      (bus_ack_o),
    .rdata_hi_i (bus_dat_o[DATA_W-1:serial_regbank_pkg::ST_PE+1]),
    .start_i    (tx_start_o),
    .cancel_i   (link_cancel_o),
    .parity_i   (cfg_parity_o),
    .incr_i     (cfg_incr_o)
);

// File: tb/serial_regbank_tb_top.sv
module serial_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] adr, wdat, rdat;
    logic [3:0]  sel;
    logic        we, stb, cyc, ack, stall;
    logic        rxv, rxp, rxf, txd;
    logic [7:0]  rxb, txb;
    logic        txs, cancel, two_stop, eight_bit;
    logic [1:0]  parity;
    logic [15:0] incr;

    int total = 0;
    int bad   = 0;

    // Reference state
    logic        m_rxne, m_oe, m_fe, m_pe, m_busy;
    logic [7:0]  m_rxd, m_txb;
    logic [31:0] m_cr;
    logic        e_ack, e_start, e_cancel;
    logic [31:0] e_dat;
    logic        last_start, last_cancel;
    logic [31:0] got;

    always #5 clk = ~clk;

    serial_regbank dut_i (
        .clk_i(clk), .rst_i(rst), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_dat_o(rdat),
        .bus_sel_i(sel), .bus_we_i(we), .bus_stb_i(stb), .bus_cyc_i(cyc),
        .bus_ack_o(ack), .bus_stall_o(stall), .rx_valid_i(rxv), .rx_byte_i(rxb),
        .rx_parity_err_i(rxp), .rx_frame_err_i(rxf), .tx_done_i(txd),
        .tx_start_o(txs), .tx_byte_o(txb), .link_cancel_o(cancel),
        .cfg_parity_o(parity), .cfg_two_stop_o(two_stop), .cfg_eight_bit_o(eight_bit),
        .cfg_incr_o(incr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        return {27'b0, m_pe, m_fe, m_oe, !m_busy, m_rxne};
    endfunction

    task automatic model_step();
        logic        acc, hit, rd_sr, rd_rx, wr_cr, wr_tx, chg, ovr, launch;
        logic [1:0]  idx;
        logic [31:0] merged;
        if (rst) begin
            {m_rxne, m_oe, m_fe, m_pe, m_busy} = '0;
            m_rxd = '0; m_txb = '0; m_cr = '0;
            e_ack = 0; e_start = 0; e_cancel = 0; e_dat = '0;
            return;
        end
        acc   = stb && cyc;
        hit   = acc && (adr[31:4] == '0) && (adr[1:0] == 2'b00);
        idx   = adr[3:2];
        e_ack = acc;
        e_dat = '0;
        if (hit && !we) begin
            case (idx)
                2'd0: e_dat = m_status();
                2'd1: e_dat = m_cr;
                2'd2: e_dat = {24'b0, m_rxd};
                default: e_dat = '0;
            endcase
        end
        rd_sr = hit && !we && idx == 2'd0;
        rd_rx = hit && !we && idx == 2'd2;
        wr_cr = hit && we && idx == 2'd1;
        wr_tx = hit && we && idx == 2'd3;
        merged = m_cr;
        for (int lane = 0; lane < 4; lane++)
            if (sel[lane]) merged[lane*8 +: 8] = wdat[lane*8 +: 8];
        merged   = merged & 32'hFFFF_000F;
        chg      = wr_cr && (merged != m_cr);
        e_cancel = chg;
        launch   = wr_tx && !m_busy;
        e_start  = launch;
        if (launch) m_txb = wdat[7:0];
        if (chg) m_busy = 0;
        else if (launch) m_busy = 1;
        else if (txd) m_busy = 0;
        ovr = rxv && m_rxne && !rd_rx;
        if (rxv && !ovr) begin m_rxd = rxb; m_rxne = 1; end
        else if (rd_rx) begin m_rxd = '0; m_rxne = 0; end
        if (ovr) m_oe = 1; else if (rd_sr) m_oe = 0;
        if (rxv && rxp) m_pe = 1; else if (rd_sr) m_pe = 0;
        if (rxv && rxf) m_fe = 1; else if (rd_sr) m_fe = 0;
        if (wr_cr) m_cr = merged;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R1 ack", {31'b0, ack}, {31'b0, e_ack});
        chk("R1 stall", {31'b0, stall}, 32'b0);
        chk("R3/R4/R6/R11 rdata", rdat, e_dat);
        chk("R9 tx_start", {31'b0, txs}, {31'b0, e_start});
        chk("R9 tx_byte", {24'b0, txb}, {24'b0, m_txb});
        chk("R5 cancel", {31'b0, cancel}, {31'b0, e_cancel});
        chk("R4 cfg", {incr, 12'b0, eight_bit, two_stop, parity},
            {m_cr[31:16], 12'b0, m_cr[3:0]});
    endtask

    task automatic clear_in();
        stb = 0; cyc = 0; we = 0; sel = '0; adr = '0; wdat = '0;
        rxv = 0; rxp = 0; rxf = 0; rxb = '0; txd = 0;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        adr = a; wdat = d; sel = s; we = 1; stb = 1; cyc = 1;
        tick();
        last_start = txs; last_cancel = cancel;
        clear_in();
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        adr = a; we = 0; sel = 4'hF; stb = 1; cyc = 1;
        tick();
        d = rdat;
        clear_in();
    endtask

    task automatic rx_event(input logic [7:0] b, input logic pe, input logic fe);
        rxv = 1; rxb = b; rxp = pe; rxf = fe;
        tick();
        clear_in();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int acks;
        clear_in();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        // R2 reset state
        bus_read(32'h0, got);  chk("R2 status after reset", got, 32'h2);
        bus_read(32'h4, got);  chk("R2 control after reset", got, 32'h0);
        bus_read(32'h8, got);  chk("R2 rxdata after reset", got, 32'h0);
        // R4 / R5 control writes
        bus_write(32'h4, 32'h1234_FFF9, 4'hF);
        chk("R5 cancel on change", {31'b0, last_cancel}, 32'h1);
        bus_read(32'h4, got);  chk("R4 reserved bits dropped", got, 32'h1234_0009);
        chk("R4 cfg fields", {incr, 12'b0, eight_bit, two_stop, parity}, 32'h1234_0009);
        bus_write(32'h4, 32'h1234_0009, 4'hF);
        chk("R5 no cancel on same value", {31'b0, last_cancel}, 32'h0);
        bus_write(32'h4, 32'hAB00_0000, 4'b1000);
        bus_read(32'h4, got);  chk("R4 lane 3 only", got, 32'hAB34_0009);
        bus_write(32'h4, 32'h0000_0006, 4'b0001);
        chk("R4 even parity two stop", {30'b0, parity}, 32'h2);
        chk("R4 seven bits", {31'b0, eight_bit}, 32'h0);
        // R6 receive path
        rx_event(8'h5A, 0, 0);
        bus_read(32'h0, got);  chk("R6 full flag", got, 32'h3);
        bus_read(32'h8, got);  chk("R6 byte read", got, 32'h5A);
        bus_read(32'h8, got);  chk("R6 cleared after read", got, 32'h0);
        bus_read(32'h0, got);  chk("R6 full flag cleared", got, 32'h2);
        // R7 overrun
        rx_event(8'h11, 0, 0);
        rx_event(8'h22, 0, 0);
        bus_read(32'h0, got);  chk("R7 overrun flagged", got, 32'h7);
        bus_read(32'h8, got);  chk("R7 old byte kept", got, 32'h11);
        bus_read(32'h0, got);  chk("R8 overrun cleared by read", got, 32'h2);
        // R8 error flags
        rx_event(8'h3C, 1, 1);
        bus_read(32'h0, got);  chk("R8 parity and framing", got, 32'h1B);
        bus_read(32'h0, got);  chk("R8 errors cleared", got, 32'h3);
        bus_read(32'h8, got);  chk("R8 byte with errors", got, 32'h3C);
        rxv = 1; rxb = 8'h44; rxp = 1;
        bus_read(32'h0, got);  chk("R8 read sees old flags", got, 32'h2);
        bus_read(32'h0, got);  chk("R8 set wins over clear", got, 32'h13);
        bus_read(32'h8, got);  chk("R8 byte", got, 32'h44);
        // R7 read and receive in one cycle
        rx_event(8'h61, 0, 0);
        rxv = 1; rxb = 8'h62;
        bus_read(32'h8, got);  chk("R7 read returns first", got, 32'h61);
        bus_read(32'h0, got);  chk("R7 no overrun on same-cycle read", got, 32'h3);
        bus_read(32'h8, got);  chk("R7 second byte stored", got, 32'h62);
        // R9 transmit handoff
        bus_write(32'hC, 32'hFFFF_FFC3, 4'hF);
        chk("R9 start pulse", {31'b0, last_start}, 32'h1);
        chk("R9 byte out", {24'b0, txb}, 32'hC3);
        bus_read(32'h0, got);  chk("R9 busy clears empty", got, 32'h0);
        bus_write(32'hC, 32'h55, 4'hF);
        chk("R9 write while busy dropped", {31'b0, last_start}, 32'h0);
        chk("R9 byte unchanged", {24'b0, txb}, 32'hC3);
        txd = 1; tick(); clear_in();
        bus_read(32'h0, got);  chk("R9 done sets empty", got, 32'h2);
        // R10 cancel ends a send
        bus_write(32'hC, 32'h77, 4'hF);
        bus_read(32'h0, got);  chk("R10 busy", got, 32'h0);
        bus_write(32'h4, 32'h1, 4'b0001);
        chk("R10 cancel pulse", {31'b0, last_cancel}, 32'h1);
        bus_read(32'h0, got);  chk("R10 empty after cancel", got, 32'h2);
        // R11 ignored accesses
        bus_write(32'h0, 32'hFFFF_FFFF, 4'hF);
        bus_write(32'h8, 32'hFFFF_FFFF, 4'hF);
        bus_write(32'h14, 32'hFFFF_FFFF, 4'hF);
        bus_write(32'h5, 32'hFFFF_FFFF, 4'hF);
        bus_read(32'h0, got);  chk("R11 status untouched", got, 32'h2);
        bus_read(32'h8, got);  chk("R11 rxdata untouched", got, 32'h0);
        bus_read(32'h4, got);  chk("R11 control untouched", got, 32'hAB34_0001);
        bus_read(32'hC, got);  chk("R11 txdata reads zero", got, 32'h0);
        bus_read(32'h10, got); chk("R11 unmapped reads zero", got, 32'h0);
        // R1 back-to-back and gated strobe
        acks = 0;
        stb = 1; cyc = 1; we = 0; sel = 4'hF;
        adr = 32'h4; tick(); acks += int'(ack);
        adr = 32'h0; tick(); acks += int'(ack);
        adr = 32'h8; tick(); acks += int'(ack);
        clear_in(); tick();
        chk("R1 three pipelined acks", acks, 3);
        chk("R1 ack drops", {31'b0, ack}, 32'h0);
        stb = 1; cyc = 0; tick(); clear_in(); tick();
        chk("R1 no ack without cycle", {31'b0, ack}, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule